// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds the instructions waiting for one functional unit in an out-of-order scheduler. It has four slots. When an instruction is issued, it lands in a free slot. For each of its two sources, the issuer supplies one of two things:

- a resolved value, taken either from the register file or from a reorder-buffer entry that has already completed;
- the reorder-buffer tag of the producer that has not finished yet.

The slot also stores the reorder-buffer tag of its own result.

Every slot watches the shared result bus. When a pending source sees its tag on the bus, it captures the value. An instruction broadcast in the same cycle as the issue is forwarded straight into the new slot. When both sources of a slot are resolved, the slot is ready. One ready slot per cycle is sent to the execution unit, and the oldest one by issue order wins. A slot that has been sent stays occupied until its own destination tag appears on the bus, and then it is freed.

When every slot is occupied, the pool lowers its ready-to-accept output. The issuer must then hold the instruction, because this is a structural stall. Execution and arbitration of the result bus happen outside this block.

Top module: `rs_tag_pool`

## Requirements
- R1: After reset no slot is occupied, `iss_ready` is 1 and `disp_valid` is 0.
- R2: An issue is taken only when `iss_valid` is 1 and `iss_ready` is 1. `iss_ready` is 0 exactly when all four slots are occupied, and an issue attempted in that state changes nothing.
- R3: A source issued with its wait flag at 0 uses the supplied value unchanged when it is dispatched.
- R4: A source issued with its wait flag at 1 ignores the supplied value. It waits until a bus cycle whose tag equals the stored tag, and then holds that bus value.
- R5: If the bus carries the tag of a source in the same cycle that source is issued, the source captures the bus value at issue.
- R6: A slot is dispatched only when both of its sources are resolved, and it is dispatched exactly once while it is occupied. Dispatch is visible on the cycle after the slot became ready.
- R7: When several slots are ready, the one issued earliest is dispatched. At most one slot is dispatched per cycle.
- R8: A slot is freed on the clock edge at which the bus carries its destination tag. Its place is available to issue on the next cycle.
- R9: A dispatch presents the slot's op code, both source values and its destination tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Reorder-buffer tag of this instruction's result |
| iss_a_wait | input | 1 | Source A still waits for a producer |
| iss_a_tag | input | TAG_W | Producer tag of source A |
| iss_a_val | input | DATA_W | Value of source A when not waiting |
| iss_b_wait | input | 1 | Source B still waits for a producer |
| iss_b_tag | input | TAG_W | Producer tag of source B |
| iss_b_val | input | DATA_W | Value of source B when not waiting |
| iss_ready | output | 1 | A free slot exists |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_val | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A slot is sent to execution this cycle |
| disp_op | output | OP_W | Op code of the dispatched slot |
| disp_dst | output | TAG_W | Destination tag of the dispatched slot |
| disp_a | output | DATA_W | Source A value of the dispatched slot |
| disp_b | output | DATA_W | Source B value of the dispatched slot |

## Verification
Corrupted internal state becomes visible at the ports within a few cycles:

- A slot that misses a bus match never dispatches, and the pool later stays full.
- A wrongly captured operand appears on `disp_a` or `disp_b` as soon as that slot is dispatched.
- A broken age order swaps the sequence of destination tags on `disp_dst` in the first cycle where two slots are ready together.
- A slot that is not freed keeps `iss_ready` low one cycle longer than the model predicts.

A reference model compares the issue readiness and every dispatch field on every cycle, so each of these faults is reported on the first cycle where it changes an output.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_WAIT = 2'd1,
    SL_SENT = 2'd2
  } slot_st_e;
endpackage

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 4,
  parameter int AGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic              in_a_wait,
  input  logic [TAG_W-1:0]  in_a_tag,
  input  logic [DATA_W-1:0] in_a_val,
  input  logic              in_b_wait,
  input  logic [TAG_W-1:0]  in_b_tag,
  input  logic [DATA_W-1:0] in_b_val,
  input  logic [AGE_W-1:0]  alloc_age,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              launch,
  input  logic              rel_any,
  input  logic [AGE_W-1:0]  rel_age,
  output logic              busy,
  output logic              ready,
  output logic              rel_o,
  output logic [AGE_W-1:0]  age,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dst,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);
  slot_st_e            st_q, st_d;
  logic [AGE_W-1:0]    age_q, age_d;
  logic [OP_W-1:0]     op_q, op_d;
  logic [TAG_W-1:0]    dst_q, dst_d, at_q, at_d, bt_q, bt_d;
  logic                aw_q, aw_d, bw_q, bw_d;
  logic [DATA_W-1:0]   av_q, av_d, bv_q, bv_d;
  logic                a_hit, b_hit, a_fwd, b_fwd, data_en;

  assign busy  = (st_q != SL_FREE);
  assign ready = (st_q == SL_WAIT) && !aw_q && !bw_q;
  assign rel_o = busy && bus_valid && (bus_tag == dst_q);
  assign a_hit = busy && aw_q && bus_valid && (bus_tag == at_q);
  assign b_hit = busy && bw_q && bus_valid && (bus_tag == bt_q);
  assign a_fwd = in_a_wait && bus_valid && (bus_tag == in_a_tag);
  assign b_fwd = in_b_wait && bus_valid && (bus_tag == in_b_tag);
  assign data_en = alloc || a_hit || b_hit;

  always_comb begin
    st_d  = st_q;
    age_d = age_q;
    op_d  = op_q;
    dst_d = dst_q;
    aw_d  = aw_q;
    at_d  = at_q;
    av_d  = av_q;
    bw_d  = bw_q;
    bt_d  = bt_q;
    bv_d  = bv_q;
    if (alloc) begin
      st_d  = SL_WAIT;
      age_d = alloc_age;
      op_d  = in_op;
      dst_d = in_dst;
      aw_d  = in_a_wait && !a_fwd;
      at_d  = in_a_tag;
      av_d  = a_fwd ? bus_val : in_a_val;
      bw_d  = in_b_wait && !b_fwd;
      bt_d  = in_b_tag;
      bv_d  = b_fwd ? bus_val : in_b_val;
    end else begin
      if (a_hit) begin
        aw_d = 1'b0;
        av_d = bus_val;
      end
      if (b_hit) begin
        bw_d = 1'b0;
        bv_d = bus_val;
      end
      if (launch) st_d = SL_SENT;
      if (rel_o) st_d = SL_FREE;
      if (busy && rel_any && !rel_o && (rel_age < age_q)) age_d = age_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SL_FREE;
      age_q <= '0;
      aw_q  <= 1'b0;
      bw_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      age_q <= age_d;
      aw_q  <= aw_d;
      bw_q  <= bw_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      op_q  <= op_d;
      dst_q <= dst_d;
      at_q  <= at_d;
      av_q  <= av_d;
      bt_q  <= bt_d;
      bv_q  <= bv_d;
    end
  end

  assign age   = age_q;
  assign op    = op_q;
  assign dst   = dst_q;
  assign a_val = av_q;
  assign b_val = bv_q;
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int SLOTS = 4,
  parameter int AGE_W = 2
) (
  input  logic [SLOTS-1:0]       ready,
  input  logic [SLOTS*AGE_W-1:0] ages,
  output logic [SLOTS-1:0]       grant
);
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      grant[i] = ready[i];
      for (int j = 0; j < SLOTS; j++) begin
        if (j != i && ready[j] &&
            (ages[j*AGE_W +: AGE_W] < ages[i*AGE_W +: AGE_W]))
          grant[i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_tag_pool.sv
module rs_tag_pool #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              iss_a_wait,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic              iss_b_wait,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  output logic              iss_ready,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [TAG_W-1:0]  disp_dst,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b
);
  localparam int AGE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0]       busy_v, rdy_v, rel_v, grant_v, alloc_v;
  logic [SLOTS*AGE_W-1:0] age_flat;
  logic [OP_W-1:0]        s_op  [SLOTS];
  logic [TAG_W-1:0]       s_dst [SLOTS];
  logic [DATA_W-1:0]      s_a   [SLOTS];
  logic [DATA_W-1:0]      s_b   [SLOTS];
  logic [AGE_W:0]         live_cnt;
  logic [AGE_W-1:0]       alloc_age, rel_age;
  logic                   found;

  always_comb begin
    found   = 1'b0;
    alloc_v = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!busy_v[i] && !found) begin
        alloc_v[i] = iss_valid;
        found      = 1'b1;
      end
    end
  end
  assign iss_ready = found;

  always_comb begin
    live_cnt = '0;
    rel_age  = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (busy_v[i] && !rel_v[i]) live_cnt = live_cnt + 1'b1;
      if (rel_v[i]) rel_age = rel_age | age_flat[i*AGE_W +: AGE_W];
    end
  end
  assign alloc_age = live_cnt[AGE_W-1:0];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    rs_slot #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .AGE_W(AGE_W)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (alloc_v[g]),
      .in_op     (iss_op),
      .in_dst    (iss_dst),
      .in_a_wait (iss_a_wait),
      .in_a_tag  (iss_a_tag),
      .in_a_val  (iss_a_val),
      .in_b_wait (iss_b_wait),
      .in_b_tag  (iss_b_tag),
      .in_b_val  (iss_b_val),
      .alloc_age (alloc_age),
      .bus_valid (cdb_valid),
      .bus_tag   (cdb_tag),
      .bus_val   (cdb_val),
      .launch    (grant_v[g]),
      .rel_any   (|rel_v),
      .rel_age   (rel_age),
      .busy      (busy_v[g]),
      .ready     (rdy_v[g]),
      .rel_o     (rel_v[g]),
      .age       (age_flat[g*AGE_W +: AGE_W]),
      .op        (s_op[g]),
      .dst       (s_dst[g]),
      .a_val     (s_a[g]),
      .b_val     (s_b[g])
    );
  end

  rs_age_pick #(.SLOTS(SLOTS), .AGE_W(AGE_W)) u_pick (
    .ready (rdy_v),
    .ages  (age_flat),
    .grant (grant_v)
  );

  always_comb begin
    disp_op  = '0;
    disp_dst = '0;
    disp_a   = '0;
    disp_b   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (grant_v[i]) begin
        disp_op  = disp_op  | s_op[i];
        disp_dst = disp_dst | s_dst[i];
        disp_a   = disp_a   | s_a[i];
        disp_b   = disp_b   | s_b[i];
      end
    end
  end
  assign disp_valid = |grant_v;
endmodule

// File: rtl/rs_tag_pool_chk.sv
module rs_tag_pool_chk #(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic              iss_a_wait,
  input logic [TAG_W-1:0]  iss_a_tag,
  input logic              iss_b_wait,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic [DATA_W-1:0] cdb_val,
  input logic              disp_valid,
  input logic [DATA_W-1:0] disp_a,
  input logic [SLOTS-1:0]  busy_v,
  input logic [SLOTS-1:0]  rdy_v,
  input logic [SLOTS-1:0]  grant_v,
  input logic [SLOTS-1:0]  rel_v
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_v)); // R7

  AST_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_v & ~rdy_v) == '0); // R6

  AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_v != '0) |=> ((grant_v & $past(grant_v)) == '0)); // R6

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_ready && !cdb_valid) |=> !iss_ready); // R2

  AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_v != '0) |=> iss_ready); // R8

  AST_FWD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && busy_v == '0 && iss_a_wait && !iss_b_wait && cdb_valid &&
     cdb_tag == iss_a_tag) |=> (disp_valid && disp_a == $past(cdb_val))); // R5
endmodule

bind rs_tag_pool rs_tag_pool_chk #(.SLOTS(SLOTS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/sim_rs_tag_pool.sv
`timescale 1ns/1ps
module sim_rs_tag_pool;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_a_wait, iss_b_wait, iss_ready;
  logic [3:0]  iss_op;
  logic [2:0]  iss_dst, iss_a_tag, iss_b_tag, cdb_tag, disp_dst;
  logic [31:0] iss_a_val, iss_b_val, cdb_val, disp_a, disp_b;
  logic        cdb_valid, disp_valid;
  logic [3:0]  disp_op;

  always #2 clk = ~clk;

  rs_tag_pool u0 (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  bit          m_busy [N], m_sent [N], m_aw [N], m_bw [N];
  int          m_seq [N];
  logic [3:0]  m_op [N];
  logic [2:0]  m_dst [N], m_at [N], m_bt [N];
  logic [31:0] m_av [N], m_bv [N];
  int          seq_ctr = 0;
  int          m_g;

  task automatic check(bit ok, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic bit any_free();
    for (int i = 0; i < N; i++) if (!m_busy[i]) return 1;
    return 0;
  endfunction

  task automatic compare();
    bit fr;
    m_g = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_sent[i] && !m_aw[i] && !m_bw[i] &&
          (m_g < 0 || m_seq[i] < m_seq[m_g])) m_g = i;
    fr = any_free();
    check(iss_ready === fr, "R2 iss_ready", iss_ready, fr);
    check(disp_valid === (m_g >= 0), "R6 disp_valid", disp_valid, m_g >= 0);
    if (m_g >= 0 && disp_valid === 1'b1) begin
      check(disp_dst === m_dst[m_g], "R7 oldest disp_dst", disp_dst, m_dst[m_g]);
      check(disp_op === m_op[m_g], "R9 disp_op", disp_op, m_op[m_g]);
      check(disp_a === m_av[m_g], "R4 disp_a", disp_a, m_av[m_g]);
      check(disp_b === m_bv[m_g], "R3 disp_b", disp_b, m_bv[m_g]);
    end
  endtask

  task automatic model_update();
    bit acc = iss_valid && any_free();
    int k = -1;
    for (int i = 0; i < N; i++) begin
      if (!m_busy[i]) begin
        if (k < 0) k = i;
      end else begin
        if (cdb_valid && m_aw[i] && cdb_tag == m_at[i]) begin m_aw[i] = 0; m_av[i] = cdb_val; end
        if (cdb_valid && m_bw[i] && cdb_tag == m_bt[i]) begin m_bw[i] = 0; m_bv[i] = cdb_val; end
        if (i == m_g) m_sent[i] = 1;
        if (cdb_valid && cdb_tag == m_dst[i]) m_busy[i] = 0;
      end
    end
    if (acc) begin
      m_busy[k] = 1; m_sent[k] = 0; m_seq[k] = seq_ctr++;
      m_op[k] = iss_op; m_dst[k] = iss_dst;
      m_at[k] = iss_a_tag; m_bt[k] = iss_b_tag;
      m_aw[k] = iss_a_wait && !(cdb_valid && cdb_tag == iss_a_tag);
      m_av[k] = (iss_a_wait && !m_aw[k]) ? cdb_val : iss_a_val;
      m_bw[k] = iss_b_wait && !(cdb_valid && cdb_tag == iss_b_tag);
      m_bv[k] = (iss_b_wait && !m_bw[k]) ? cdb_val : iss_b_val;
    end
  endtask

  task automatic cycle();
    compare();
    model_update();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    iss_valid = 0; iss_op = '0; iss_dst = '0;
    iss_a_wait = 0; iss_a_tag = '0; iss_a_val = '0;
    iss_b_wait = 0; iss_b_tag = '0; iss_b_val = '0;
    cdb_valid = 0; cdb_tag = '0; cdb_val = '0;
  endtask

  function automatic bit dst_in_use(logic [2:0] t);
    for (int i = 0; i < N; i++) if (m_busy[i] && m_dst[i] == t) return 1;
    return 0;
  endfunction

  task automatic pick_src(output logic w, output logic [2:0] t);
    int cand[$];
    for (int i = 0; i < N; i++) if (m_busy[i]) cand.push_back(i);
    w = ($urandom % 2) != 0;
    if (w && cand.size() > 0 && ($urandom % 2) != 0)
      t = m_dst[cand[$urandom % cand.size()]];
    else
      t = 3'(4 + $urandom % 4);
  endtask

  task automatic random_inputs();
    int sent[$];
    iss_valid = ($urandom % 3) != 0;
    iss_op = 4'($urandom);
    iss_dst = 3'd0;
    for (int t = 0; t < 4; t++) if (!dst_in_use(3'(t))) begin iss_dst = 3'(t); break; end
    pick_src(iss_a_wait, iss_a_tag);
    pick_src(iss_b_wait, iss_b_tag);
    iss_a_val = $urandom; iss_b_val = $urandom;
    for (int i = 0; i < N; i++) if (m_busy[i] && m_sent[i]) sent.push_back(i);
    cdb_valid = ($urandom % 2) != 0;
    if (sent.size() > 0 && ($urandom % 2) != 0) cdb_tag = m_dst[sent[$urandom % sent.size()]];
    else cdb_tag = 3'(4 + $urandom % 4);
    if (cdb_valid && cdb_tag < 4 && !dst_in_use(cdb_tag)) cdb_tag = 3'd7;
    cdb_val = $urandom;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    for (int i = 0; i < N; i++) begin m_busy[i] = 0; m_sent[i] = 0; end
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle after reset
    check(iss_ready === 1'b1, "R1 iss_ready", iss_ready, 1);
    check(disp_valid === 1'b0, "R1 disp_valid", disp_valid, 0);

    // R5: bus forward in issue cycle, B resolved at issue
    iss_valid = 1; iss_op = 4'h5; iss_dst = 3'd1;
    iss_a_wait = 1; iss_a_tag = 3'd6; iss_a_val = 32'hdead;
    iss_b_wait = 0; iss_b_val = 32'h1234;
    cdb_valid = 1; cdb_tag = 3'd6; cdb_val = 32'hcafe_0001;
    cycle();
    idle_inputs();
    check(disp_valid === 1'b1 && disp_a === 32'hcafe_0001, "R5 forward",
          disp_a, 32'hcafe_0001);
    cycle();
    check(disp_valid === 1'b0, "R6 single dispatch", disp_valid, 0);
    cdb_valid = 1; cdb_tag = 3'd1; cdb_val = 32'h0;
    cycle();
    idle_inputs();

    // R2: fill four slots waiting on tag 5, then try a fifth
    for (int s = 0; s < 4; s++) begin
      iss_valid = 1; iss_op = 4'(s); iss_dst = 3'(s);
      iss_a_wait = 1; iss_a_tag = 3'd5; iss_a_val = 32'hbad;
      iss_b_wait = 0; iss_b_val = 32'(100 + s);
      cycle();
    end
    check(iss_ready === 1'b0, "R2 full", iss_ready, 0);
    iss_valid = 1; iss_dst = 3'd4;
    cycle();
    idle_inputs();
    // R4/R7: wake all at once; oldest (dst 0) first
    cdb_valid = 1; cdb_tag = 3'd5; cdb_val = 32'h7777;
    cycle();
    idle_inputs();
    for (int s = 0; s < 4; s++) begin
      check(disp_dst === 3'(s), "R7 order", disp_dst, s);
      check(disp_a === 32'h7777, "R4 capture", disp_a, 32'h7777);
      cycle();
    end
    // R8: release tag 2, then room opens
    cdb_valid = 1; cdb_tag = 3'd2;
    cycle();
    idle_inputs();
    check(iss_ready === 1'b1, "R8 release", iss_ready, 1);
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin cdb_valid = 1; cdb_tag = 3'(s); cycle(); end
    end
    idle_inputs();

    for (int c = 0; c < 20000; c++) begin
      random_inputs();
      cycle();
    end
    idle_inputs();
    cycle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule